// File: doc/BRIEF.md
# Register Busy Scoreboard for a Multi-Warp Core

This block records which architectural registers have a write still in flight, so that the issue stage of a multi-warp core holds back any instruction that would read a stale value. It keeps three busy tables. The integer and floating-point tables hold one row of busy bits per warp. The vector table is a single row that every warp shares.

Each cycle the issue side presents a warp number, up to seven source operands (two integer, three floating-point, two vector) and up to three destinations (one per register file), with a qualifier bit on every operand. The block reports at once, in the same cycle, whether the candidate may go ahead. An accepted candidate marks its destinations busy. A refused candidate is flagged as stalled; it changes nothing and is expected to be presented again. A writeback side names the warp and destinations of a retiring instruction and frees them. A free taking place in the same cycle is already visible to the issue check in that cycle. Integer register 0 is a constant and is never tracked. Register 0 of the floating-point and vector files is an ordinary register.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every register of every file and every warp reads as free, so any candidate presented is accepted.
- R2: A candidate with `iss_valid` high is refused (`iss_stall`=1, `iss_accept`=0) when any qualified source of any of its seven source slots names a busy register. Otherwise it is accepted (`iss_stall`=0, `iss_accept`=1). Both outputs are 0 while `iss_valid` is low. Both outputs follow the inputs in the same cycle.
- R3: Integer index 0 is never tracked. An integer destination of 0 marks nothing, and an integer source of 0 never causes a stall.
- R4: Index 0 of the floating-point file and of the vector file is tracked like any other index.
- R5: On an accepted candidate, each qualified destination becomes busy from the next clock edge.
- R6: A writeback with `wb_valid` high frees each qualified destination it names from the next clock edge.
- R7: A source freed by a writeback in the current cycle is treated as free by the issue check in that cycle.
- R8: Integer and floating-point busy bits are separate for each warp. Vector busy bits are shared by all warps.
- R9: A refused candidate marks none of its destinations busy.
- R10: A source whose qualifier bit is low is not checked, even if its index names a busy register.
- R11: When an accepted candidate sets a bit and a writeback frees the same bit in the same cycle, the bit is busy afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue candidate present |
| iss_warp | input | WID_W | Warp of the candidate |
| iss_isrc_vld | input | 2 | Integer source qualifiers |
| iss_isrc_idx | input | 2 x IDX_W | Integer source indices |
| iss_fsrc_vld | input | 3 | Floating-point source qualifiers |
| iss_fsrc_idx | input | 3 x IDX_W | Floating-point source indices |
| iss_vsrc_vld | input | 2 | Vector source qualifiers |
| iss_vsrc_idx | input | 2 x IDX_W | Vector source indices |
| iss_idst_vld | input | 1 | Integer destination qualifier |
| iss_idst_idx | input | IDX_W | Integer destination index |
| iss_fdst_vld | input | 1 | Floating-point destination qualifier |
| iss_fdst_idx | input | IDX_W | Floating-point destination index |
| iss_vdst_vld | input | 1 | Vector destination qualifier |
| iss_vdst_idx | input | IDX_W | Vector destination index |
| wb_valid | input | 1 | Writeback present |
| wb_warp | input | WID_W | Warp of the retiring instruction |
| wb_idst_vld | input | 1 | Integer destination to free |
| wb_idst_idx | input | IDX_W | Integer index to free |
| wb_fdst_vld | input | 1 | Floating-point destination to free |
| wb_fdst_idx | input | IDX_W | Floating-point index to free |
| wb_vdst_vld | input | 1 | Vector destination to free |
| wb_vdst_idx | input | IDX_W | Vector index to free |
| iss_stall | output | 1 | Candidate refused because a source is busy |
| iss_accept | output | 1 | Candidate accepted; its destinations are marked |

## Verification
On every cycle the assertions check several properties. A mark follows an accepted destination, and a free follows a writeback. A set wins over a free of the same bit. No bit moves in a cycle without a mark or a free. An issue that reads only integer index 0, has no qualified sources, or reads a register being freed in that cycle is never refused. Other behaviour needs the bench's scenarios against its reference tables: the clean state after reset, sharing of the vector row against separation of the integer and floating-point rows across warps, and a refused candidate leaving its destinations free. The same holds for tracking of floating-point and vector index 0 and for each of the seven source slots causing a stall.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int unsigned SB_INT_SRCS = 2;
   localparam int unsigned SB_FP_SRCS  = 3;
   localparam int unsigned SB_VEC_SRCS = 2;

   // pointer width that stays at least one bit for single-entry spaces
   function automatic int unsigned sb_ptr_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sb_bank.sv
// One busy table: ROWS rows of NREG bits, one set port and one free port.
// view presents the table with the current-cycle free already applied.
module sb_bank #(
   parameter int unsigned ROWS      = 4,
   parameter int unsigned NREG      = 32,
   parameter bit          SKIP_ZERO = 1'b0,
   parameter int unsigned ROW_W     = 2,
   parameter int unsigned IDX_W     = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           set_en,
   input  logic [ROW_W-1:0]               set_row,
   input  logic [IDX_W-1:0]               set_idx,
   input  logic                           clr_en,
   input  logic [ROW_W-1:0]               clr_row,
   input  logic [IDX_W-1:0]               clr_idx,
   output logic [ROWS-1:0][NREG-1:0]      view
);
   logic [ROWS-1:0][NREG-1:0] busy_q;

   for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
      for (genvar gb = 0; gb < NREG; gb++) begin : g_bit
         logic hit_clr;
         logic q;
         assign hit_clr = clr_en && (clr_row == ROW_W'(gr)) && (clr_idx == IDX_W'(gb));
         if (SKIP_ZERO && gb == 0) begin : g_untracked
            assign q = 1'b0;
         end else begin : g_tracked
            logic hit_set;
            assign hit_set = set_en && (set_row == ROW_W'(gr)) && (set_idx == IDX_W'(gb));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       q <= 1'b0;
               else if (hit_set) q <= 1'b1;
               else if (hit_clr) q <= 1'b0;
            end
         end
         assign busy_q[gr][gb] = q;
         assign view[gr][gb]   = q & ~hit_clr;
      end
   end

   AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !(SKIP_ZERO && set_idx == '0)) |=> busy_q[$past(set_row)][$past(set_idx)]); // R5
   AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_row == clr_row && set_idx == clr_idx))
      |=> !busy_q[$past(clr_row)][$past(clr_idx)]); // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en && set_row == clr_row && set_idx == clr_idx && !(SKIP_ZERO && set_idx == '0))
      |=> busy_q[$past(set_row)][$past(set_idx)]); // R11
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(busy_q)); // R9
endmodule

// File: rtl/sb_lookup.sv
// Checks NQ qualified source indices of one row against a busy view.
module sb_lookup #(
   parameter int unsigned ROWS  = 4,
   parameter int unsigned NREG  = 32,
   parameter int unsigned NQ    = 2,
   parameter int unsigned ROW_W = 2,
   parameter int unsigned IDX_W = 5
) (
   input  logic [ROWS-1:0][NREG-1:0] view,
   input  logic [ROW_W-1:0]          row,
   input  logic [NQ-1:0]             q_vld,
   input  logic [NQ-1:0][IDX_W-1:0]  q_idx,
   output logic                      any_busy
);
   logic [NQ-1:0] hit;
   for (genvar gq = 0; gq < NQ; gq++) begin : g_q
      assign hit[gq] = q_vld[gq] & view[row][q_idx[gq]];
   end
   assign any_busy = |hit;
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
   import sb_pkg::*;
#(
   parameter int unsigned NUM_WARPS = 4,
   parameter int unsigned NUM_REGS  = 32,
   localparam int unsigned WID_W    = sb_ptr_w(NUM_WARPS),
   localparam int unsigned IDX_W    = sb_ptr_w(NUM_REGS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                iss_valid,
   input  logic [WID_W-1:0]                    iss_warp,
   input  logic [SB_INT_SRCS-1:0]              iss_isrc_vld,
   input  logic [SB_INT_SRCS-1:0][IDX_W-1:0]   iss_isrc_idx,
   input  logic [SB_FP_SRCS-1:0]               iss_fsrc_vld,
   input  logic [SB_FP_SRCS-1:0][IDX_W-1:0]    iss_fsrc_idx,
   input  logic [SB_VEC_SRCS-1:0]              iss_vsrc_vld,
   input  logic [SB_VEC_SRCS-1:0][IDX_W-1:0]   iss_vsrc_idx,
   input  logic                                iss_idst_vld,
   input  logic [IDX_W-1:0]                    iss_idst_idx,
   input  logic                                iss_fdst_vld,
   input  logic [IDX_W-1:0]                    iss_fdst_idx,
   input  logic                                iss_vdst_vld,
   input  logic [IDX_W-1:0]                    iss_vdst_idx,
   input  logic                                wb_valid,
   input  logic [WID_W-1:0]                    wb_warp,
   input  logic                                wb_idst_vld,
   input  logic [IDX_W-1:0]                    wb_idst_idx,
   input  logic                                wb_fdst_vld,
   input  logic [IDX_W-1:0]                    wb_fdst_idx,
   input  logic                                wb_vdst_vld,
   input  logic [IDX_W-1:0]                    wb_vdst_idx,
   output logic                                iss_stall,
   output logic                                iss_accept
);
   if (NUM_WARPS < 1) begin : g_bad_warps
      $error("reg_scoreboard: NUM_WARPS must be at least 1");
   end
   if (NUM_REGS < 2 || (2 ** IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("reg_scoreboard: NUM_REGS must be a power of two, at least 2");
   end

   logic [NUM_WARPS-1:0][NUM_REGS-1:0] int_view, fp_view;
   logic [0:0][NUM_REGS-1:0]           vec_view;
   logic int_busy, fp_busy, vec_busy;

   assign iss_stall  = iss_valid &  (int_busy | fp_busy | vec_busy);
   assign iss_accept = iss_valid & ~(int_busy | fp_busy | vec_busy);

   sb_bank #(.ROWS(NUM_WARPS), .NREG(NUM_REGS), .SKIP_ZERO(1'b1), .ROW_W(WID_W), .IDX_W(IDX_W)) u_int_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(iss_accept & iss_idst_vld), .set_row(iss_warp), .set_idx(iss_idst_idx),
      .clr_en(wb_valid & wb_idst_vld), .clr_row(wb_warp), .clr_idx(wb_idst_idx),
      .view(int_view));

   sb_bank #(.ROWS(NUM_WARPS), .NREG(NUM_REGS), .SKIP_ZERO(1'b0), .ROW_W(WID_W), .IDX_W(IDX_W)) u_fp_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(iss_accept & iss_fdst_vld), .set_row(iss_warp), .set_idx(iss_fdst_idx),
      .clr_en(wb_valid & wb_fdst_vld), .clr_row(wb_warp), .clr_idx(wb_fdst_idx),
      .view(fp_view));

   sb_bank #(.ROWS(1), .NREG(NUM_REGS), .SKIP_ZERO(1'b0), .ROW_W(1), .IDX_W(IDX_W)) u_vec_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(iss_accept & iss_vdst_vld), .set_row(1'b0), .set_idx(iss_vdst_idx),
      .clr_en(wb_valid & wb_vdst_vld), .clr_row(1'b0), .clr_idx(wb_vdst_idx),
      .view(vec_view));

   sb_lookup #(.ROWS(NUM_WARPS), .NREG(NUM_REGS), .NQ(SB_INT_SRCS), .ROW_W(WID_W), .IDX_W(IDX_W)) u_int_look (
      .view(int_view), .row(iss_warp), .q_vld(iss_isrc_vld), .q_idx(iss_isrc_idx), .any_busy(int_busy));

   sb_lookup #(.ROWS(NUM_WARPS), .NREG(NUM_REGS), .NQ(SB_FP_SRCS), .ROW_W(WID_W), .IDX_W(IDX_W)) u_fp_look (
      .view(fp_view), .row(iss_warp), .q_vld(iss_fsrc_vld), .q_idx(iss_fsrc_idx), .any_busy(fp_busy));

   sb_lookup #(.ROWS(1), .NREG(NUM_REGS), .NQ(SB_VEC_SRCS), .ROW_W(1), .IDX_W(IDX_W)) u_vec_look (
      .view(vec_view), .row(1'b0), .q_vld(iss_vsrc_vld), .q_idx(iss_vsrc_idx), .any_busy(vec_busy));

   AST_INT_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !(|iss_fsrc_vld) && !(|iss_vsrc_vld)
       && (!iss_isrc_vld[0] || iss_isrc_idx[0] == '0)
       && (!iss_isrc_vld[1] || iss_isrc_idx[1] == '0)) |-> iss_accept); // R3
   AST_UNQUALIFIED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !(|iss_isrc_vld) && !(|iss_fsrc_vld) && !(|iss_vsrc_vld)) |-> iss_accept); // R10
   AST_SAME_CYCLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && wb_valid && wb_idst_vld && wb_warp == iss_warp
       && iss_isrc_vld == 2'b01 && iss_isrc_idx[0] == wb_idst_idx
       && !(|iss_fsrc_vld) && !(|iss_vsrc_vld)) |-> iss_accept); // R7
endmodule

// File: tb/reg_scoreboard_tb_top.sv
`timescale 1ns/1ps
module reg_scoreboard_tb_top;
   localparam int NW = 4;
   localparam int NR = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_valid;
   logic [1:0] iss_warp;
   logic [1:0] isv; logic [1:0][4:0] isi;
   logic [2:0] fsv; logic [2:0][4:0] fsi;
   logic [1:0] vsv; logic [1:0][4:0] vsi;
   logic idv, fdv, vdv; logic [4:0] idi, fdi, vdi;
   logic wb_valid; logic [1:0] wb_warp;
   logic widv, wfdv, wvdv; logic [4:0] widi, wfdi, wvdi;
   logic iss_stall, iss_accept;

   int total = 0;
   int bad = 0;
   bit done = 0;

   bit m_int [NW][NR];
   bit m_fp  [NW][NR];
   bit m_vec [NR];

   always #4 clk = ~clk;

   reg_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR)) dut_i (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_warp(iss_warp),
      .iss_isrc_vld(isv), .iss_isrc_idx(isi), .iss_fsrc_vld(fsv), .iss_fsrc_idx(fsi),
      .iss_vsrc_vld(vsv), .iss_vsrc_idx(vsi),
      .iss_idst_vld(idv), .iss_idst_idx(idi), .iss_fdst_vld(fdv), .iss_fdst_idx(fdi),
      .iss_vdst_vld(vdv), .iss_vdst_idx(vdi),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_idst_vld(widv), .wb_idst_idx(widi),
      .wb_fdst_vld(wfdv), .wb_fdst_idx(wfdi), .wb_vdst_vld(wvdv), .wb_vdst_idx(wvdi),
      .iss_stall(iss_stall), .iss_accept(iss_accept));

   // reference view with the same-cycle free applied (R7)
   function automatic bit int_busy_at(input int w, input int r);
      if (r == 0) return 0; // R3
      return m_int[w][r] && !(wb_valid && widv && int'(wb_warp) == w && int'(widi) == r);
   endfunction
   function automatic bit fp_busy_at(input int w, input int r);
      return m_fp[w][r] && !(wb_valid && wfdv && int'(wb_warp) == w && int'(wfdi) == r);
   endfunction
   function automatic bit vec_busy_at(input int r);
      return m_vec[r] && !(wb_valid && wvdv && int'(wvdi) == r);
   endfunction
   function automatic bit exp_busy();
      bit b = 0;
      for (int i = 0; i < 2; i++) if (isv[i] && int_busy_at(iss_warp, isi[i])) b = 1;
      for (int i = 0; i < 3; i++) if (fsv[i] && fp_busy_at(iss_warp, fsi[i])) b = 1;
      for (int i = 0; i < 2; i++) if (vsv[i] && vec_busy_at(vsi[i])) b = 1;
      return b;
   endfunction

   task automatic idle();
      iss_valid = 0; iss_warp = 0; isv = 0; isi = '0; fsv = 0; fsi = '0; vsv = 0; vsi = '0;
      idv = 0; idi = 0; fdv = 0; fdi = 0; vdv = 0; vdi = 0;
      wb_valid = 0; wb_warp = 0; widv = 0; widi = 0; wfdv = 0; wfdi = 0; wvdv = 0; wvdi = 0;
   endtask

   task automatic step(input string req);
      bit eb, es, ea;
      #1;
      eb = exp_busy();
      es = iss_valid && eb;
      ea = iss_valid && !eb;
      total++;
      if (iss_stall !== es || iss_accept !== ea) begin
         bad++;
         $display("FAIL %s: stall,accept actual=%b,%b expected=%b,%b", req, iss_stall, iss_accept, es, ea);
      end
      @(posedge clk);
      if (wb_valid && widv) m_int[wb_warp][widi] = 0;
      if (wb_valid && wfdv) m_fp[wb_warp][wfdi] = 0;
      if (wb_valid && wvdv) m_vec[wvdi] = 0;
      if (ea) begin // R11: mark after free
         if (idv && idi != 0) m_int[iss_warp][idi] = 1;
         if (fdv) m_fp[iss_warp][fdi] = 1;
         if (vdv) m_vec[vdi] = 1;
      end
      @(negedge clk);
   endtask

   task automatic probe_int(input int w, input int r, input string req);
      idle(); iss_valid = 1; iss_warp = 2'(w); isv = 2'b01; isi[0] = 5'(r); step(req);
   endtask
   task automatic probe_fp(input int w, input int r, input string req);
      idle(); iss_valid = 1; iss_warp = 2'(w); fsv = 3'b001; fsi[0] = 5'(r); step(req);
   endtask
   task automatic probe_vec(input int w, input int r, input string req);
      idle(); iss_valid = 1; iss_warp = 2'(w); vsv = 2'b01; vsi[0] = 5'(r); step(req);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: everything free after reset
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < NR; r++) begin
            idle(); iss_valid = 1; iss_warp = 2'(w);
            isv = 2'b11; isi[0] = 5'(r); isi[1] = 5'(NR - 1 - r);
            fsv = 3'b111; fsi[0] = 5'(r); fsi[1] = 5'(r); fsi[2] = 5'(NR - 1 - r);
            vsv = 2'b11; vsi[0] = 5'(r); vsi[1] = 5'(NR - 1 - r);
            step("R1");
         end
      idle(); step("R2 idle outputs");

      // R5/R4: warp1 marks int 5, fp 0, vec 0
      idle(); iss_valid = 1; iss_warp = 1; idv = 1; idi = 5; fdv = 1; fdi = 0; vdv = 1; vdi = 0;
      step("R5 mark");
      probe_int(1, 5, "R5 int busy");
      probe_fp(1, 0, "R4 fp zero tracked");
      probe_vec(1, 0, "R4 vec zero tracked");
      probe_vec(3, 0, "R8 vec shared");
      probe_int(2, 5, "R8 int per warp");
      probe_fp(2, 0, "R8 fp per warp");

      // R3: int dest 0 marks nothing, int src 0 never stalls
      idle(); iss_valid = 1; iss_warp = 0; idv = 1; idi = 0; step("R3 mark zero");
      probe_int(0, 0, "R3 int zero free");

      // R2: each of the seven slots can stall (int 5 / fp 0 on warp1, vec 0)
      for (int s = 0; s < 7; s++) begin
         idle(); iss_valid = 1; iss_warp = 1;
         isi[0] = 5; isi[1] = 5; fsi = '0; vsi = '0;
         if (s < 2) isv[s] = 1'b1;
         else if (s < 5) fsv[s - 2] = 1'b1;
         else vsv[s - 5] = 1'b1;
         step("R2 slot stall");
      end

      // R9: refused candidate with dest int 7 marks nothing
      idle(); iss_valid = 1; iss_warp = 1; isv = 2'b01; isi[0] = 5; idv = 1; idi = 7;
      fdv = 1; fdi = 9; vdv = 1; vdi = 9;
      step("R9 refused");
      probe_int(1, 7, "R9 int dest untouched");
      probe_fp(1, 9, "R9 fp dest untouched");
      probe_vec(1, 9, "R9 vec dest untouched");

      // R10: unqualified source pointing at busy register
      idle(); iss_valid = 1; iss_warp = 1; isv = 2'b00; isi[0] = 5; isi[1] = 5;
      fsv = 3'b000; vsv = 2'b00; step("R10 unqualified");

      // R7: same-cycle free visible to issue
      idle(); iss_valid = 1; iss_warp = 1; isv = 2'b01; isi[0] = 5;
      wb_valid = 1; wb_warp = 1; widv = 1; widi = 5; step("R7 bypass");
      probe_int(1, 5, "R6 int freed");
      idle(); wb_valid = 1; wb_warp = 1; wfdv = 1; wfdi = 0; wvdv = 1; wvdi = 0; step("R6 free");
      probe_fp(1, 0, "R6 fp freed");
      probe_vec(2, 0, "R6 vec freed");

      // R11: set and free of the same bit together
      idle(); iss_valid = 1; iss_warp = 0; fdv = 1; fdi = 9;
      wb_valid = 1; wb_warp = 0; wfdv = 1; wfdi = 9; step("R11 collide");
      probe_fp(0, 9, "R11 set wins");

      // random traffic over a small index range to force collisions
      seed = 32'h1234_abcd;
      void'($urandom(seed));
      for (int n = 0; n < 4000; n++) begin
         idle();
         iss_valid = ($urandom % 4) != 0;
         iss_warp = 2'($urandom);
         isv = 2'($urandom); fsv = 3'($urandom); vsv = 2'($urandom);
         for (int i = 0; i < 2; i++) isi[i] = 5'($urandom % 8);
         for (int i = 0; i < 3; i++) fsi[i] = 5'($urandom % 8);
         for (int i = 0; i < 2; i++) vsi[i] = 5'($urandom % 8);
         idv = 1'($urandom); idi = 5'($urandom % 8);
         fdv = 1'($urandom); fdi = 5'($urandom % 8);
         vdv = ($urandom % 3) == 0; vdi = 5'($urandom % 8);
         wb_valid = ($urandom % 3) != 0;
         wb_warp = 2'($urandom);
         widv = 1'($urandom); widi = 5'($urandom % 8);
         wfdv = 1'($urandom); wfdi = 5'($urandom % 8);
         wvdv = 1'($urandom); wvdi = 5'($urandom % 8);
         step("R2 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule